// File: doc/BRIEF.md
# MDIO Management Master Controller

This block lets software talk to external Ethernet PHYs over the two-wire management bus (MDC clock, MDIO data) using clause 22 frames. Software sees two 32-bit registers on a simple memory-mapped bus: a command register and a data register. To write a PHY register, software loads the data register, then writes the command register with the start bit and the write bit set. To read, it writes the command register with start set and write clear, polls until busy drops, and then reads the captured 16-bit value from the data register.

The controller divides the host clock down to MDC using a 3-bit clock-range code, so MDC stays within the bus limit across host clock bands. It shifts out 32 preamble ones, the start pattern, the opcode, the PHY address, the register number and the turnaround, and then either drives or samples 16 data bits, all most significant bit first. Outputs change only while MDC is low, and input data is sampled on the rising edge of MDC.

A single state machine sequences the frame through the states S_IDLE, S_PRE, S_HDR, S_TA, S_DATA and S_END. S_IDLE goes to S_PRE when busy is set. S_PRE goes to S_HDR after 32 bit times. S_HDR goes to S_TA after 14 bit times. S_TA goes to S_DATA after 2 bit times. S_DATA goes to S_END after 16 bit times. S_END returns to S_IDLE after one host cycle, and busy clears on that same step.

Top module: `mdio_host`

## Requirements
- R1: After reset, busy (command bit 0) reads 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: The command register is at byte offset 0x10 and the data register at 0x14. The command register holds busy in bit 0, write select in bit 1 (1 = write, 0 = read), the clock-range code in bits 4:2, the register number in bits 10:6 and the PHY address in bits 15:11. Bit 5 and bits 31:16 read 0. The data register holds 16 bits in bits 15:0. Both read back what was written while idle.
- R3: One MDC period lasts 42, 62, 16, 26, 102 and 124 host cycles for codes 0 to 5, and 124 host cycles for codes 6 and 7.
- R4: A write frame sampled at the 64 rising MDC edges is 32 ones, start 01, opcode 01, the PHY address, the register number, turnaround 10, and then the 16-bit data value held when busy was set, with `mdio_oe` high throughout. The frame is unaffected by data register writes made during it.
- R5: A read frame carries opcode 10. `mdio_oe` is 0 at the two turnaround edges and at the 16 data edges. The 16 bits on `mdio_i` at the rising MDC edges appear in the data register once busy reads 0.
- R6: Busy stays 1 from the start write until the frame ends and is then cleared by hardware, leaving `mdc` low and `mdio_oe` 0.
- R7: A command register write while busy is 1 is ignored: the register contents and the frame in progress are unchanged.
- R8: Reading the data register during a read frame returns its previous contents.
- R9: `mdio_o` and `mdio_oe` change only while `mdc` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The embedded assertions check on every cycle that busy holds until the frame-end pulse, that the divider count never passes its half-period limit, that MDC idles low outside a frame, that the data pins stay still while MDC is high, and that a command write during busy leaves the command fields alone. Only the bench scenarios can show the content of whole frames: the preamble, header, turnaround and data bit order, the opcode for each direction, the measured MDC period for each code, and the value a read lands in the data register. The bench also confirms that a data register change made mid-frame does not reach the wire.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;
    localparam int HALF_W = 6;
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int DAT_BITS = 16;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h14;

    typedef enum logic [2:0] {S_IDLE, S_PRE, S_HDR, S_TA, S_DATA, S_END} phase_t;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regn;
        logic [2:0] range;
        logic       wr;
        logic       busy;
    } cmd_t;

    function automatic logic [HALF_W-1:0] half_of(input logic [2:0] code);
        case (code)
            3'd0:    half_of = 6'd21;
            3'd1:    half_of = 6'd31;
            3'd2:    half_of = 6'd8;
            3'd3:    half_of = 6'd13;
            3'd4:    half_of = 6'd51;
            default: half_of = 6'd62;
        endcase
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] range,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = half_of(range);
    assign wrap = run && (cnt == half - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: divider count stays below the half period of the selected code
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done,
    input  logic [15:0]       cap_data,
    output cmd_t              cmd,
    output logic [15:0]       data
);
    logic cmd_wr, dat_wr, unused_ok;

    assign cmd_wr = bus_sel && bus_we && (bus_addr == OFS_CMD);
    assign dat_wr = bus_sel && bus_we && (bus_addr == OFS_DATA);
    assign unused_ok = ^{bus_wdata[31:16], bus_wdata[5]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd  <= '0;
            data <= '0;
        end else begin
            if (done) begin
                cmd.busy <= 1'b0;
                if (!cmd.wr) data <= cap_data;
            end else if (cmd_wr && !cmd.busy) begin
                cmd.busy  <= bus_wdata[0];
                cmd.wr    <= bus_wdata[1];
                cmd.range <= bus_wdata[4:2];
                cmd.regn  <= bus_wdata[10:6];
                cmd.phy   <= bus_wdata[15:11];
            end
            if (dat_wr && !done) data <= bus_wdata[15:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CMD)
            bus_rdata = {16'h0, cmd.phy, cmd.regn, 1'b0, cmd.range, cmd.wr, cmd.busy};
        else if (bus_addr == OFS_DATA)
            bus_rdata = {16'h0, data};
    end

    // R6: busy only drops on the frame-end pulse
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.busy && !done) |=> cmd.busy);
    // R7: command fields do not move on a write made while busy
    a_r7_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.busy && !done && cmd_wr) |=> $stable({cmd.phy, cmd.regn, cmd.range, cmd.wr}));
endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  cmd_t        cmd,
    input  logic [15:0] wdata,
    input  logic        mdc,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        run,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] sr
);
    phase_t                state;
    logic [4:0]            bitcnt;
    logic [HDR_BITS-1:0]   hdr;
    logic                  wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            bitcnt <= '0;
            hdr    <= '0;
            sr     <= '0;
            wr_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (cmd.busy) begin
                    state  <= S_PRE;
                    bitcnt <= 5'(PRE_BITS - 1);
                    hdr    <= {2'b01, cmd.wr ? 2'b01 : 2'b10, cmd.phy, cmd.regn};
                    sr     <= wdata;
                    wr_q   <= cmd.wr;
                end
                S_PRE: if (fall) begin
                    if (bitcnt == 0) begin
                        state  <= S_HDR;
                        bitcnt <= 5'(HDR_BITS - 1);
                    end else bitcnt <= bitcnt - 1'b1;
                end
                S_HDR: if (fall) begin
                    hdr <= hdr << 1;
                    if (bitcnt == 0) begin
                        state  <= S_TA;
                        bitcnt <= 5'd1;
                    end else bitcnt <= bitcnt - 1'b1;
                end
                S_TA: if (fall) begin
                    if (bitcnt == 0) begin
                        state  <= S_DATA;
                        bitcnt <= 5'(DAT_BITS - 1);
                    end else bitcnt <= bitcnt - 1'b1;
                end
                S_DATA: begin
                    if (rise && !wr_q) sr <= {sr[14:0], mdio_i};
                    if (fall) begin
                        if (wr_q) sr <= sr << 1;
                        if (bitcnt == 0) state <= S_END;
                        else bitcnt <= bitcnt - 1'b1;
                    end
                end
                S_END: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        run = 1'b0; done = 1'b0; mdio_o = 1'b0; mdio_oe = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_PRE:  begin run = 1'b1; mdio_o = 1'b1;     mdio_oe = 1'b1; end
            S_HDR:  begin run = 1'b1; mdio_o = hdr[HDR_BITS-1]; mdio_oe = 1'b1; end
            S_TA:   begin run = 1'b1; mdio_o = wr_q && bitcnt[0]; mdio_oe = wr_q; end
            S_DATA: begin run = 1'b1; mdio_o = wr_q && sr[15];    mdio_oe = wr_q; end
            S_END:  done = 1'b1;
            default: ;
        endcase
    end

    // R9: data pins hold still while MDC is high
    a_r9_pins_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R6: MDC rests low whenever no frame runs
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mdc);
endmodule

// File: rtl/mdio_host.sv
module mdio_host
    import mdio_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    cmd_t        cmd;
    logic [15:0] data, cap;
    logic        run, done, rise, fall;

    mdio_regs u_regs (
        .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .done, .cap_data(cap), .cmd, .data
    );

    mdio_clkgen u_clk (
        .clk, .rst_n, .run, .range(cmd.range), .mdc, .rise, .fall
    );

    mdio_fsm u_fsm (
        .clk, .rst_n, .cmd, .wdata(data), .mdc, .rise, .fall, .mdio_i,
        .run, .done, .mdio_o, .mdio_oe, .sr(cap)
    );

    // R1: no drive on the data pin outside an active frame
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/mdio_host_test.sv
module mdio_host_test;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    mdio_host uut (.*);

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0, nrise = 0, t0 = 0, t1 = 0;
    logic [63:0] cap_bit, cap_oe;
    logic [15:0] resp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        if (nrise < 64) begin
            cap_bit[63-nrise] <= mdio_o;
            cap_oe[63-nrise]  <= mdio_oe;
        end
        if (nrise == 0) t0 <= cyc;
        if (nrise == 1) t1 <= cyc;
        nrise <= nrise + 1;
    end

    initial mdio_i = 1'b1;
    always @(negedge mdc) begin
        if (nrise >= 48 && nrise < 64) mdio_i = resp[63-nrise];
        else mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            bus_read(8'h10, v);
            if (!v[0]) begin ok = 1; break; end
        end
    endtask

    function automatic logic [31:0] cmdw(input logic [4:0] phy, input logic [4:0] rg,
                                         input logic [2:0] code, input bit wr, input bit go);
        return {16'h0, phy, rg, 1'b0, code, wr, go};
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        bus_read(8'h10, v);
        check(v[0] == 0, "R1 busy after reset", v, 0);
        check(mdc == 0 && mdio_oe == 0, "R1 pins after reset", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        bus_write(8'h10, cmdw(5'h1A, 5'h07, 3'd3, 1, 0) | 32'hFFFF_0020);
        bus_read(8'h10, v);
        check(v == cmdw(5'h1A, 5'h07, 3'd3, 1, 0), "R2 command readback", v, cmdw(5'h1A, 5'h07, 3'd3, 1, 0));
        bus_write(8'h14, 32'h1234_BEEF);
        bus_read(8'h14, v);
        check(v == 32'h0000_BEEF, "R2 data readback", v, 32'hBEEF);
    endtask

    task automatic t_write_frame;
        logic [31:0] v;
        logic [63:0] exp;
        bit ok;
        bus_write(8'h14, 32'hA5C3);
        nrise = 0;
        bus_write(8'h10, cmdw(5'h11, 5'h1E, 3'd2, 1, 1));
        bus_read(8'h10, v);
        check(v[0] == 1, "R6 busy set at start", v, 1);
        repeat (300) @(negedge clk);
        bus_write(8'h10, cmdw(5'h02, 5'h03, 3'd0, 0, 1));
        bus_write(8'h14, 32'h0F0F);
        bus_read(8'h10, v);
        check(v == cmdw(5'h11, 5'h1E, 3'd2, 1, 1), "R7 command locked while busy", v, cmdw(5'h11, 5'h1E, 3'd2, 1, 1));
        wait_idle(ok);
        check(ok, "R6 busy clears", ok, 1);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h1E, 2'b10, 16'hA5C3};
        check(cap_bit == exp, "R4 write frame bits", cap_bit, exp);
        check(cap_oe == '1, "R4 write frame drive", cap_oe, '1);
        check(nrise == 64, "R4 edge count", nrise, 64);
        check(t1 - t0 == 16, "R3 period code 2", t1 - t0, 16);
        check(mdc == 0 && mdio_oe == 0, "R6 pins after frame", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_read_frame;
        logic [31:0] v;
        logic [63:0] exp, eoe;
        bit ok;
        bus_write(8'h14, 32'h5555);
        resp = 16'h3C96;
        nrise = 0;
        bus_write(8'h10, cmdw(5'h03, 5'h02, 3'd3, 0, 1));
        repeat (26 * 55) @(negedge clk);
        bus_read(8'h14, v);
        check(v == 32'h5555, "R8 data during read frame", v, 32'h5555);
        wait_idle(ok);
        check(ok, "R6 busy clears after read", ok, 1);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h02, 18'h0};
        eoe = {46'h3FFF_FFFF_FFFF, 18'h0};
        check((cap_bit & eoe) == exp, "R5 read header bits", cap_bit & eoe, exp);
        check(cap_oe == eoe, "R5 read release", cap_oe, eoe);
        bus_read(8'h14, v);
        check(v == 32'h3C96, "R5 captured data", v, 32'h3C96);
        check(t1 - t0 == 26, "R3 period code 3", t1 - t0, 26);
        check(mdio_oe == 0, "R9 idle after read", mdio_oe, 0);
    endtask

    task automatic t_div(input logic [2:0] code, input int per);
        bit ok;
        resp = 16'h0001;
        nrise = 0;
        bus_write(8'h10, cmdw(5'h01, 5'h01, code, 0, 1));
        wait_idle(ok);
        check(ok && t1 - t0 == per, $sformatf("R3 period code %0d", code), t1 - t0, per);
    endtask

    initial begin
        #(200000 * 20);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_write_frame();
        t_read_frame();
        t_div(3'd0, 42);
        t_div(3'd6, 124);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule